// File: doc/BRIEF.md
# Pixel Row Sequencer

The block steps a rolling-shutter pixel matrix through its rows one at a time. It also produces the digital control strobes that the pixels and the column discriminators need inside each row slot. A row slot lasts a fixed number of clocks, 16 by default. During a slot the block asserts a one-hot row select. It enables power on the selected row and on the row after it. It raises the select of the 16-row group that holds the current row. It also emits a fixed sequence of phase strobes: clamp for correlated double sampling, read, calibrate and latch.

Slots advance in ascending row order. After the last row the sequence wraps to row 0, and a one-cycle frame-start marker flags the first clock of every frame. An enable input starts the sequence and stops it. While enable is low, every output stays low and the position returns to row 0. The next run therefore always begins with row 0.

Top module: `row_seq`

## Requirements
- R1: Each row slot lasts SLOT (16) clocks. During slot N, `row_sel` has exactly bit N set, and slots follow in ascending row order.
- R2: During slot N, `pwr_en` has exactly two bits set: bit N and bit (N+1) mod ROWS. Once the sequence is running, each row's power is therefore high for 32 consecutive clocks, and that window contains its 16-clock select window.
- R3: During slot N, `grp_sel` has exactly bit N/16 set. A group select therefore stays high for 256 clocks.
- R4: `clamp` is high on cycles 0, 1 and 2 of every slot and low on all other cycles.
- R5: `rd` is high on cycles 4, 5 and 6 of every slot and low on all other cycles.
- R6: `calib` is high on cycles 8, 9 and 10 of every slot and low on all other cycles.
- R7: `latch` is high on cycle 12 of every slot only.
- R8: The slot after row ROWS-1 is row 0. `frame_start` is high for exactly one clock, cycle 0 of row 0, in every frame, including the first frame after enable.
- R9: While `enable` is low, all outputs are low and the position returns to row 0. The first clock edge that sees `enable` high starts cycle 0 of row 0.
- R10: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the sequence when high; clears it when low |
| row_sel | output | ROWS | One-hot row select |
| pwr_en | output | ROWS | Row power enables, current and next row |
| grp_sel | output | ROWS/16 | One-hot group select |
| clamp | output | 1 | Clamp strobe for double sampling |
| rd | output | 1 | Discriminator read strobe |
| calib | output | 1 | Discriminator calibrate strobe |
| latch | output | 1 | Discriminator latch strobe |
| frame_start | output | 1 | One-cycle marker at the first clock of each frame |

## Verification
The bench builds the sequencer with 48 rows, which gives three groups of 16 rows and a frame of 768 clocks. A full frame and its wrap to row 0 then fit in a short run. The bench visits every strobe edge within a slot, each group boundary, the last row, and the first slots after the wrap. The default of 576 rows adds no new timing relation: it only lengthens the frame.

// File: rtl/row_seq.sv
module row_seq #(
  parameter int ROWS       = 576,
  parameter int SLOT       = 16,
  parameter int GROUP_ROWS = 16,
  parameter int PULSE      = 3,
  parameter int CLAMP_AT   = 0,
  parameter int READ_AT    = 4,
  parameter int CAL_AT     = 8,
  parameter int LATCH_AT   = 12,
  localparam int GROUPS    = ROWS / GROUP_ROWS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  output logic [ROWS-1:0]   row_sel,
  output logic [ROWS-1:0]   pwr_en,
  output logic [GROUPS-1:0] grp_sel,
  output logic              clamp,
  output logic              rd,
  output logic              calib,
  output logic              latch,
  output logic              frame_start
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(SLOT);
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  logic          active;
  logic [CW-1:0] cyc;
  logic [RW-1:0] row;
  logic [RW-1:0] row_nxt;
  logic [GW-1:0] grp;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      active <= 1'b0;
      cyc    <= '0;
      row    <= '0;
    end else if (!active) begin
      active <= 1'b1;
    end else if (cyc == CW'(SLOT - 1)) begin
      cyc <= '0;
      row <= row_nxt;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  assign row_nxt = (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
  assign grp     = GW'(row / RW'(GROUP_ROWS));

  function automatic logic in_win(input logic [CW-1:0] c, input int at, input int len);
    logic [CW-1:0] d;
    d = c - CW'(at);
    return d < CW'(len);
  endfunction

  assign row_sel     = active ? (ROWS'(1) << row) : '0;
  assign pwr_en      = active ? ((ROWS'(1) << row) | (ROWS'(1) << row_nxt)) : '0;
  assign grp_sel     = active ? (GROUPS'(1) << grp) : '0;
  assign clamp       = active && in_win(cyc, CLAMP_AT, PULSE);
  assign rd          = active && in_win(cyc, READ_AT, PULSE);
  assign calib       = active && in_win(cyc, CAL_AT, PULSE);
  assign latch       = active && (cyc == CW'(LATCH_AT));
  assign frame_start = active && (row == '0) && (cyc == '0);
endmodule

module row_seq_chk #(
  parameter int ROWS   = 576,
  parameter int GROUPS = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [ROWS-1:0]   row_sel,
  input logic [ROWS-1:0]   pwr_en,
  input logic [GROUPS-1:0] grp_sel,
  input logic              clamp,
  input logic              rd,
  input logic              calib,
  input logic              latch,
  input logic              frame_start
);
  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp_sel) |-> $onehot(row_sel)); // R1
  AST_ROW_CHANGES_AT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ((|row_sel) && (|$past(row_sel)) && !$stable(row_sel)) |-> clamp); // R1
  AST_PWR_COVERS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (row_sel & ~pwr_en) == '0); // R2
  AST_PWR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (|row_sel) |-> ($countones(pwr_en) == 2)); // R2
  AST_GRP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_sel) && ((|grp_sel) == (|row_sel))); // R3
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clamp, rd, calib, latch})); // R4
  AST_CLAMP_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clamp) && enable) |=> clamp); // R4
  AST_LATCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> !latch); // R7
  AST_FRAME_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (row_sel[0] && clamp)); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (row_sel == '0 && pwr_en == '0 && !clamp && !frame_start)); // R9
endmodule

bind row_seq row_seq_chk #(.ROWS(ROWS), .GROUPS(GROUPS)) u_chk (.*);

// File: tb/sim_row_seq.sv
module sim_row_seq;
  localparam int ROWS   = 48;
  localparam int GROUPS = 3;
  localparam int FRAME  = ROWS * 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enable = 1'b0;
  logic [ROWS-1:0]   row_sel;
  logic [ROWS-1:0]   pwr_en;
  logic [GROUPS-1:0] grp_sel;
  logic              clamp, rd, calib, latch, frame_start;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  row_seq #(.ROWS(ROWS)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .row_sel(row_sel), .pwr_en(pwr_en), .grp_sel(grp_sel),
    .clamp(clamp), .rd(rd), .calib(calib), .latch(latch),
    .frame_start(frame_start)
  );

  // {clocks since start, expected row, {clamp,rd,calib,latch}}
  localparam int NV = 18;
  localparam logic [27:0] VEC [NV] = '{
    {16'd0,   8'd0,  4'b1000}, {16'd2,   8'd0,  4'b1000},
    {16'd3,   8'd0,  4'b0000}, {16'd4,   8'd0,  4'b0100},
    {16'd6,   8'd0,  4'b0100}, {16'd7,   8'd0,  4'b0000},
    {16'd8,   8'd0,  4'b0010}, {16'd10,  8'd0,  4'b0010},
    {16'd11,  8'd0,  4'b0000}, {16'd12,  8'd0,  4'b0001},
    {16'd15,  8'd0,  4'b0000}, {16'd16,  8'd1,  4'b1000},
    {16'd255, 8'd15, 4'b0000}, {16'd256, 8'd16, 4'b1000},
    {16'd500, 8'd31, 4'b0100}, {16'd767, 8'd47, 4'b0000},
    {16'd768, 8'd0,  4'b1000}, {16'd777, 8'd0,  4'b0010}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic start_run(input int t);
    @(negedge clk) enable = 1'b0;
    @(negedge clk) enable = 1'b1;
    @(posedge clk);
    repeat (t) @(posedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(row_sel == '0 && pwr_en == '0 && grp_sel == '0 &&
        {clamp, rd, calib, latch, frame_start} == '0,
        "R10", "reset outputs", 64'(row_sel), 64'd0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #2;
    chk(row_sel == '0 && pwr_en == '0, "R9", "disabled after reset", 64'(pwr_en), 64'd0);

    for (int i = 0; i < NV; i++) begin
      int t;
      int r;
      logic [3:0] s;
      logic [ROWS-1:0] ers, epw;
      logic [GROUPS-1:0] egs;
      t = int'(VEC[i][27:12]);
      r = int'(VEC[i][11:4]);
      s = VEC[i][3:0];
      ers = ROWS'(1) << r;
      epw = ers | (ROWS'(1) << ((r + 1) % ROWS));
      egs = GROUPS'(1) << (r / 16);
      start_run(t);
      chk(row_sel == ers, "R1", $sformatf("row_sel t=%0d", t), 64'(row_sel), 64'(ers));
      chk(pwr_en == epw, "R2", $sformatf("pwr_en t=%0d", t), 64'(pwr_en), 64'(epw));
      chk(grp_sel == egs, "R3", $sformatf("grp_sel t=%0d", t), 64'(grp_sel), 64'(egs));
      chk(clamp == s[3], "R4", $sformatf("clamp t=%0d", t), 64'(clamp), 64'(s[3]));
      chk(rd == s[2], "R5", $sformatf("rd t=%0d", t), 64'(rd), 64'(s[2]));
      chk(calib == s[1], "R6", $sformatf("calib t=%0d", t), 64'(calib), 64'(s[1]));
      chk(latch == s[0], "R7", $sformatf("latch t=%0d", t), 64'(latch), 64'(s[0]));
      chk(frame_start == (t % FRAME == 0), "R8", $sformatf("frame_start t=%0d", t),
          64'(frame_start), 64'(t % FRAME == 0));
    end

    // R8: exactly one frame marker per frame over two frames
    begin
      int pulses;
      int pwr0_len;
      pulses = 0;
      pwr0_len = 0;
      start_run(0);
      for (int k = 0; k < 2 * FRAME; k++) begin
        if (frame_start) pulses++;
        if (k >= FRAME && pwr_en[5]) pwr0_len++;
        @(posedge clk); #2;
      end
      chk(pulses == 2, "R8", "frame markers in two frames", 64'(pulses), 64'd2);
      // R2: a row's power window lasts 32 clocks in steady state
      chk(pwr0_len == 32, "R2", "row 5 power length", 64'(pwr0_len), 64'd32);
    end

    // R9: dropping enable clears outputs, restart begins at row 0
    start_run(100);
    @(negedge clk) enable = 1'b0;
    @(posedge clk); #2;
    chk(row_sel == '0 && pwr_en == '0 && grp_sel == '0 && !clamp && !frame_start,
        "R9", "outputs while disabled", 64'(row_sel), 64'd0);
    @(negedge clk) enable = 1'b1;
    @(posedge clk); #2;
    chk(row_sel == ROWS'(1) && frame_start, "R9", "restart at row 0",
        64'(row_sel), 64'd1);

    // R10: reset in mid-run clears outputs
    start_run(40);
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #2;
    chk(row_sel == '0 && pwr_en == '0 && !rd, "R10", "reset mid-run",
        64'(pwr_en), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule